// File: doc/BRIEF.md
# Sound sample DMA

This block streams audio samples from a 20-bit byte-addressed source space into one of two audio sinks: the data port of a PCM channel or a secondary voice sink. It reads one byte per sample tick. A free-running 128-cycle frame counter sets the timing. A rate divider decides which frames carry a tick, so the sample rate is the 24 kHz frame rate divided by 1, 2, 4 or 6. In each frame that carries a tick, the block asserts a bus-steal signal to the CPU starting at frame cycle 117. The signal stays high for the memory access time N plus six cycles.

Software programs the block through byte-wide registers: a source address, a byte length and a control byte. Every write to a source or length byte also copies that one byte into a shadow copy. In auto-repeat mode the live source and length reload from their shadows each time the length runs out. Hold mode sends zeros to the sink and freezes the counters, while the bus-steal timing stays the same. Clearing the enable bit leaves the counters where they are, so playback resumes from the same point. A source region that takes more cycles to access only makes the steal window longer.

Top module: `snd_dma`

## Requirements
- R1: Register index 0/1/2 is source bits 7:0/15:8/19:16 and index 3/4/5 is length bits 7:0/15:8/19:16. Index 6 is control, and control bit 5 always reads 0. Reads always return the live counters. After reset, every register reads 0.
- R2: Control bits 1:0 set how often a tick comes, counted in 128-cycle frames: 0 gives a tick every 6 frames, 1 every 4, 2 every 2 and 3 every frame. The first tick after enable falls in the next frame.
- R3: Each tick's steal_o window rises at frame cycle 117 and lasts N+6 cycles. N is the number of cycles mem_req_o stays high up to and including the cycle in which mem_ready_i is high.
- R4: Each tick moves exactly one byte. The source goes up by 1 (control bit 6 = 0) or down by 1 (bit 6 = 1), wrapping modulo 2^20, and the length goes down by 1.
- R5: Control bit 4 picks the sink: 0 pulses ch_wr_o and 1 pulses voice_wr_o. The pulse lasts one cycle, falls inside the steal window and carries the byte on sample_o.
- R6: While control bit 2 (hold) is set, sample_o carries 0x00, source and length do not change, and the steal window keeps its start and length.
- R7: With control bit 3 clear, the transfer that brings the length to 0 clears enable (bit 7). The source is left one step past the last byte and the length at 0.
- R8: With control bit 3 set, the transfer that brings the length to 0 reloads the source and length from their shadow copies, and enable stays set.
- R9: A write to one source or length byte sets that byte in both the live counter and the shadow copy. The other shadow bytes do not change.
- R10: With enable clear there are no steal windows, and source and length keep their values. Setting enable again resumes from those values.
- R11: A tick that finds length 0 (with hold off) raises no steal window and no sink pulse. It applies the completion rule of R7 or R8.
- R12: mem_req_o is high only inside a steal window, and mem_addr_o then carries the live source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| mem_req_o | output | 1 | Source read request |
| mem_addr_o | output | 20 | Source byte address |
| mem_ready_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 8 | Source read data |
| steal_o | output | 1 | CPU bus-steal window |
| sample_o | output | 8 | Sample byte to the sink |
| ch_wr_o | output | 1 | Write strobe to the PCM channel port |
| voice_wr_o | output | 1 | Write strobe to the voice sink |

## Verification
The assertions check the following on every cycle:
- every steal window rises at frame cycle 117 and lasts exactly its request cycles plus six;
- memory requests and sink pulses stay inside the window, and only one sink fires at a time;
- a held tick delivers zero and leaves the counters frozen;
- the counters do not move while the block is disabled and idle.

Other behaviour needs the bench's directed scenarios:
- the rate spacing in frames and the address order;
- the one-shot clear of enable;
- the shadow reload after a single-byte rewrite mid-stream;
- resuming after a pause;
- the empty-length tick.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
  localparam int unsigned CTRL_RATE_LO = 0;
  localparam int unsigned CTRL_HOLD    = 2;
  localparam int unsigned CTRL_REPEAT  = 3;
  localparam int unsigned CTRL_TARGET  = 4;
  localparam int unsigned CTRL_DEC     = 6;
  localparam int unsigned CTRL_EN      = 7;
  localparam logic [7:0]  CTRL_MASK    = 8'hDF;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_FETCH,
    XS_TAIL
  } xfer_st_e;

  // frames per tick for each rate code
  function automatic logic [2:0] rate_div(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd6;
      2'd1:    return 3'd4;
      2'd2:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/snd_dma_frame.sv
module snd_dma_frame
  import snd_dma_pkg::*;
#(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned SLOT_AT = 117
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [1:0]         rate_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tick_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [2:0]         rate_q;
  logic               slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else         frame_q <= frame_q + 1'b1;
  end

  assign slot = (frame_q == FRAME_W'(SLOT_AT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rate_q <= '0;
    else if (!en_i)    rate_q <= '0;
    else if (slot) begin
      if (rate_q == '0) rate_q <= rate_div(rate_i) - 3'd1;
      else              rate_q <= rate_q - 3'd1;
    end
  end

  assign tick_o  = slot && en_i && (rate_q == '0);
  assign frame_o = frame_q;
endmodule

// File: rtl/snd_dma_regs.sv
module snd_dma_regs
  import snd_dma_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned NB     = (CNT_W + 7) / 8,
  parameter int unsigned REG_AW = $clog2(2 * NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              adv_i,
  input  logic              empty_i,
  output logic [7:0]        rdata_o,
  output logic [CNT_W-1:0]  src_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [7:0]        ctrl_o
);
  localparam int unsigned BW = NB * 8;

  logic [CNT_W-1:0] src_q, len_q, ssh_q, lsh_q;
  logic [CNT_W-1:0] src_n, len_n, ssh_n, lsh_n;
  logic [7:0]       ctrl_q, ctrl_n;
  logic [BW-1:0]    src_w, len_w, ssh_w, lsh_w, src_r, len_r;
  logic             hold, rep;

  assign hold = ctrl_q[CTRL_HOLD];
  assign rep  = ctrl_q[CTRL_REPEAT];

  always_comb begin
    src_n  = src_q;
    len_n  = len_q;
    ctrl_n = ctrl_q;
    if (adv_i && !hold) begin
      src_n = ctrl_q[CTRL_DEC] ? src_q - 1'b1 : src_q + 1'b1;
      len_n = len_q - 1'b1;
      if (len_n == '0) begin
        if (rep) begin
          src_n = ssh_q;
          len_n = lsh_q;
        end else begin
          ctrl_n[CTRL_EN] = 1'b0;
        end
      end
    end
    if (empty_i) begin
      if (rep) begin
        src_n = ssh_q;
        len_n = lsh_q;
      end else begin
        ctrl_n[CTRL_EN] = 1'b0;
      end
    end
    // register writes win over the counter update of the same cycle
    src_w = BW'(src_n);
    len_w = BW'(len_n);
    ssh_w = BW'(ssh_q);
    lsh_w = BW'(lsh_q);
    for (int k = 0; k < NB; k++) begin
      if (we_i && addr_i == REG_AW'(k)) begin
        src_w[k*8 +: 8] = wdata_i;
        ssh_w[k*8 +: 8] = wdata_i;
      end
      if (we_i && addr_i == REG_AW'(NB + k)) begin
        len_w[k*8 +: 8] = wdata_i;
        lsh_w[k*8 +: 8] = wdata_i;
      end
    end
    src_n = src_w[CNT_W-1:0];
    len_n = len_w[CNT_W-1:0];
    ssh_n = ssh_w[CNT_W-1:0];
    lsh_n = lsh_w[CNT_W-1:0];
    if (we_i && addr_i == REG_AW'(2 * NB)) ctrl_n = wdata_i & CTRL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      len_q  <= '0;
      ssh_q  <= '0;
      lsh_q  <= '0;
      ctrl_q <= '0;
    end else begin
      src_q  <= src_n;
      len_q  <= len_n;
      ssh_q  <= ssh_n;
      lsh_q  <= lsh_n;
      ctrl_q <= ctrl_n;
    end
  end

  always_comb begin
    src_r   = BW'(src_q);
    len_r   = BW'(len_q);
    rdata_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr_i == REG_AW'(k))      rdata_o = src_r[k*8 +: 8];
      if (addr_i == REG_AW'(NB + k)) rdata_o = len_r[k*8 +: 8];
    end
    if (addr_i == REG_AW'(2 * NB)) rdata_o = ctrl_q;
  end

  assign src_o  = src_q;
  assign len_o  = len_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/snd_dma_xfer.sv
module snd_dma_xfer
  import snd_dma_pkg::*;
#(
  parameter int unsigned STEAL_BASE = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       hold_i,
  input  logic       tgt_i,
  input  logic       mem_ready_i,
  input  logic [7:0] mem_rdata_i,
  output logic       idle_o,
  output logic       steal_o,
  output logic       mem_req_o,
  output logic       adv_o,
  output logic [7:0] sample_o,
  output logic       ch_wr_o,
  output logic       voice_wr_o
);
  localparam int unsigned TW = $clog2(STEAL_BASE + 1);

  xfer_st_e      st_q;
  logic [TW-1:0] tail_q;
  logic          fetching, capture;

  assign fetching = (st_q == XS_IDLE && start_i) || (st_q == XS_FETCH);
  assign capture  = fetching && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= XS_IDLE;
      tail_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: if (start_i) begin
          st_q   <= mem_ready_i ? XS_TAIL : XS_FETCH;
          tail_q <= '0;
        end
        XS_FETCH: if (mem_ready_i) begin
          st_q   <= XS_TAIL;
          tail_q <= '0;
        end
        XS_TAIL: begin
          tail_q <= tail_q + 1'b1;
          if (tail_q == TW'(STEAL_BASE - 1)) st_q <= XS_IDLE;
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o   <= '0;
      ch_wr_o    <= 1'b0;
      voice_wr_o <= 1'b0;
    end else begin
      ch_wr_o    <= capture && !tgt_i;
      voice_wr_o <= capture && tgt_i;
      if (capture) sample_o <= hold_i ? 8'h00 : mem_rdata_i;
    end
  end

  assign idle_o    = (st_q == XS_IDLE);
  assign steal_o   = fetching || (st_q == XS_TAIL);
  assign mem_req_o = fetching;
  assign adv_o     = capture;
endmodule

// File: rtl/snd_dma.sv
module snd_dma
  import snd_dma_pkg::*;
#(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned FRAME_W    = 7,
  parameter int unsigned SLOT_AT    = 117,
  parameter int unsigned STEAL_BASE = 6,
  localparam int unsigned NB        = (CNT_W + 7) / 8,
  localparam int unsigned REG_AW    = $clog2(2 * NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  output logic [CNT_W-1:0]  mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              steal_o,
  output logic [7:0]        sample_o,
  output logic              ch_wr_o,
  output logic              voice_wr_o
);
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   src, len;
  logic [7:0]         ctrl;
  logic               tick, idle, adv, start, empty, hold, len_nz;

  assign hold   = ctrl[CTRL_HOLD];
  assign len_nz = |len;
  assign start  = tick && idle && (len_nz || hold);
  assign empty  = tick && idle && !len_nz && !hold;

  snd_dma_frame #(.FRAME_W(FRAME_W), .SLOT_AT(SLOT_AT)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl[CTRL_EN]),
    .rate_i  (ctrl[CTRL_RATE_LO +: 2]),
    .frame_o (frame),
    .tick_o  (tick)
  );

  snd_dma_regs #(.CNT_W(CNT_W), .NB(NB), .REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .adv_i   (adv),
    .empty_i (empty),
    .rdata_o (reg_rdata_o),
    .src_o   (src),
    .len_o   (len),
    .ctrl_o  (ctrl)
  );

  snd_dma_xfer #(.STEAL_BASE(STEAL_BASE)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .hold_i      (hold),
    .tgt_i       (ctrl[CTRL_TARGET]),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .idle_o      (idle),
    .steal_o     (steal_o),
    .mem_req_o   (mem_req_o),
    .adv_o       (adv),
    .sample_o    (sample_o),
    .ch_wr_o     (ch_wr_o),
    .voice_wr_o  (voice_wr_o)
  );

  assign mem_addr_o = src;
endmodule

// File: rtl/snd_dma_chk.sv
module snd_dma_chk #(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned FRAME_W    = 7,
  parameter int unsigned SLOT_AT    = 117,
  parameter int unsigned STEAL_BASE = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic               steal_i,
  input logic               mem_req_i,
  input logic               ch_wr_i,
  input logic               voice_wr_i,
  input logic [7:0]         sample_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [7:0]         ctrl_i,
  input logic [CNT_W-1:0]   src_i,
  input logic [CNT_W-1:0]   len_i
);
  logic [7:0] st_cnt, rq_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_cnt <= '0;
      rq_cnt <= '0;
    end else if (!steal_i) begin
      st_cnt <= '0;
      rq_cnt <= '0;
    end else begin
      st_cnt <= st_cnt + 1'b1;
      rq_cnt <= rq_cnt + 8'(mem_req_i);
    end
  end

  AST_STEAL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(steal_i) |-> frame_i == FRAME_W'(SLOT_AT)); // R3
  AST_STEAL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!steal_i && $past(steal_i)) |-> st_cnt == rq_cnt + 8'(STEAL_BASE)); // R3
  AST_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> steal_i); // R12
  AST_ONE_SINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ch_wr_i, voice_wr_i})); // R5
  AST_SINK_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_wr_i || voice_wr_i) |-> (steal_i && !mem_req_i)); // R5
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_wr_i || voice_wr_i) && $past(ctrl_i[2])) |-> sample_i == 8'h00); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_i[2]) && !$past(reg_we_i)) |-> ($stable(src_i) && $stable(len_i))); // R6
  AST_OFF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ctrl_i[7]) && !$past(reg_we_i) && !$past(steal_i))
      |-> ($stable(src_i) && $stable(len_i))); // R10
endmodule

bind snd_dma snd_dma_chk #(
  .CNT_W(CNT_W), .FRAME_W(FRAME_W), .SLOT_AT(SLOT_AT), .STEAL_BASE(STEAL_BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .steal_i    (steal_o),
  .mem_req_i  (mem_req_o),
  .ch_wr_i    (ch_wr_o),
  .voice_wr_i (voice_wr_o),
  .sample_i   (sample_o),
  .frame_i    (frame),
  .ctrl_i     (ctrl),
  .src_i      (src),
  .len_i      (len)
);

// File: tb/snd_dma_test.sv
module snd_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        mem_req, mem_ready, steal, ch_wr, voice_wr;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata, sample;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int mem_n   = 1;
  int req_cnt = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memval(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
  endfunction

  assign mem_ready = mem_req && (req_cnt == mem_n - 1);
  assign mem_rdata = memval(mem_addr);

  always @(posedge clk) begin
    if (!mem_req)        req_cnt <= 0;
    else if (!mem_ready) req_cnt <= req_cnt + 1;
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  snd_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .steal_o(steal), .sample_o(sample), .ch_wr_o(ch_wr), .voice_wr_o(voice_wr)
  );

  // event log, sampled away from the active edge
  logic [7:0] smp [64];
  bit         tgt [64];
  int         rise_cyc [64];
  int         slen [64];
  int n_smp = 0, n_rise = 0, n_len = 0, run = 0;
  logic steal_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (steal && !steal_d) begin rise_cyc[n_rise % 64] = cyc; n_rise++; end
      if (steal) run++;
      else if (steal_d) begin slen[n_len % 64] = run; n_len++; run = 0; end
      if (ch_wr || voice_wr) begin
        smp[n_smp % 64] = sample; tgt[n_smp % 64] = voice_wr; n_smp++;
      end
      steal_d = steal;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n_smp = 0; n_rise = 0; n_len = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  task automatic rd20(input logic [2:0] base, output int v);
    logic [7:0] b0, b1, b2;
    rd(base, b0); rd(base + 3'd1, b1); rd(base + 3'd2, b2);
    v = {12'h0, b2[3:0], b1, b0};
  endtask

  task automatic setup(input int src, input int len, input logic [7:0] ctrl);
    wr(3'd0, src[7:0]);  wr(3'd1, src[15:8]);  wr(3'd2, {4'h0, src[19:16]});
    wr(3'd3, len[7:0]);  wr(3'd4, len[15:8]);  wr(3'd5, {4'h0, len[19:16]});
    wr(3'd6, ctrl);
  endtask

  task automatic wait_smp(input int n, input string req);
    int c = 0;
    while (n_smp < n && c < 5000) begin @(negedge clk); c++; end
    chk(req, n_smp, n);
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (steal) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_timing(input int n, input int div, input int steal_len, input string req);
    for (int i = 0; i < n; i++) begin
      chk("R3 align", rise_cyc[i] % 128, 117);
      chk("R3 length", slen[i], steal_len);
      if (i > 0) chk(req, rise_cyc[i] - rise_cyc[i-1], 128 * div);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 7; a++) begin rd(3'(a), d); chk("R1 reset read", d, 0); end
    chk("R1 reset steal", steal, 0);
    chk("R1 reset strobes", {ch_wr, voice_wr}, 0);
    wr(3'd6, 8'h2C);
    rd(3'd6, d); chk("R1 ctrl bit5 masked", d, 8'h0C);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_basic();
    int v; logic [7:0] d;
    mem_n = 1; clr_log();
    setup(20'h12345, 3, 8'h83);
    wait_smp(3, "R4 count"); wait_quiet();
    for (int i = 0; i < 3; i++) begin
      chk("R12 inc addr data", smp[i], memval(20'h12345 + 20'(i)));
      chk("R5 channel target", tgt[i], 0);
    end
    chk_timing(3, 1, 7, "R2 rate3");
    rd(3'd6, d); chk("R7 enable cleared", d, 8'h03);
    rd20(3'd0, v); chk("R7 src past end", v, 20'h12348);
    rd20(3'd3, v); chk("R7 len zero", v, 0);
    repeat (300) @(negedge clk);
    chk("R7 no more ticks", n_rise, 3);
  endtask

  task automatic t_dec();
    int v;
    mem_n = 3; clr_log();
    setup(20'h00001, 2, 8'hD1);
    wait_smp(2, "R4 dec count"); wait_quiet();
    chk("R4 dec first", smp[0], memval(20'h00001));
    chk("R4 dec second", smp[1], memval(20'h00000));
    chk("R5 voice target", tgt[0] && tgt[1], 1);
    chk_timing(2, 4, 9, "R2 rate1");
    rd20(3'd0, v); chk("R4 dec wrap", v, 20'hFFFFF);
  endtask

  task automatic t_rates();
    mem_n = 1; clr_log();
    setup(20'h00100, 2, 8'h80);
    wait_smp(2, "R2 rate0 count"); wait_quiet();
    chk_timing(2, 6, 7, "R2 rate0");
    clr_log();
    setup(20'h00100, 2, 8'h82);
    wait_smp(2, "R2 rate2 count"); wait_quiet();
    chk_timing(2, 2, 7, "R2 rate2");
  endtask

  task automatic t_hold();
    int v;
    mem_n = 2; clr_log();
    setup(20'h00500, 2, 8'h8F);
    wait_smp(3, "R6 hold ticks");
    wr(3'd6, 8'h00); wait_quiet();
    for (int i = 0; i < 3; i++) chk("R6 hold zero", smp[i], 0);
    chk_timing(3, 1, 8, "R6 hold rate");
    rd20(3'd0, v); chk("R6 src frozen", v, 20'h00500);
    rd20(3'd3, v); chk("R6 len frozen", v, 2);
  endtask

  task automatic t_repeat();
    int v; logic [7:0] d;
    mem_n = 1; clr_log();
    setup(20'h001FF, 3, 8'h8B);
    wait_smp(1, "R9 first");
    wr(3'd0, 8'h80);
    wait_smp(3, "R9 after write");
    wait_quiet();
    chk("R9 live low byte", smp[1], memval(20'h00280));
    chk("R9 live next", smp[2], memval(20'h00281));
    rd20(3'd0, v); chk("R9 shadow per byte", v, 20'h00180);
    rd20(3'd3, v); chk("R8 len reload", v, 3);
    rd(3'd6, d); chk("R8 enable kept", d, 8'h8B);
    wait_smp(4, "R8 next");
    chk("R8 reloaded data", smp[3], memval(20'h00180));
    wr(3'd6, 8'h00); wait_quiet();
  endtask

  task automatic t_pause();
    int v; logic [7:0] d;
    mem_n = 1; clr_log();
    setup(20'h03000, 4, 8'h83);
    wait_smp(2, "R10 first two");
    wr(3'd6, 8'h03); wait_quiet();
    repeat (400) @(negedge clk);
    chk("R10 no steal off", n_rise, 2);
    rd20(3'd0, v); chk("R10 src kept", v, 20'h03002);
    rd20(3'd3, v); chk("R10 len kept", v, 2);
    wr(3'd6, 8'h83);
    wait_smp(4, "R10 resume"); wait_quiet();
    chk("R10 resume addr", smp[2], memval(20'h03002));
    chk("R10 resume addr2", smp[3], memval(20'h03003));
    repeat (10) @(negedge clk);
    rd(3'd6, d); chk("R7 clear after resume", d, 8'h03);
  endtask

  task automatic t_empty();
    logic [7:0] d;
    mem_n = 1; clr_log();
    setup(20'h00010, 0, 8'h83);
    repeat (300) @(negedge clk);
    chk("R11 no steal", n_rise, 0);
    chk("R11 no strobe", n_smp, 0);
    rd(3'd6, d); chk("R11 enable cleared", d, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_dec();
    t_rates();
    t_hold();
    t_repeat();
    t_pause();
    t_empty();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule